// File: doc/BRIEF.md
# I2C Slave Paged EEPROM Controller

This block is the digital front end of a serial byte-wide non-volatile memory that sits on a two-wire I2C bus as a slave. It oversamples the bus clock and data lines with the fast system clock and recognises START and STOP. It answers one 7-bit device address, of which three bits come from strap inputs, and it keeps a word address counter for the byte array behind it. A master can write, read at a given word address, read from the current counter position, or read a run of bytes in sequence.

Writes do not reach the array while the bus transaction runs. Data bytes collect in a page buffer that holds one page of 32 bytes. A valid STOP then starts a self-timed programming window. During that window the buffered bytes are copied into the array, and the slave stays silent on the bus until the window ends. A write-protect input shields the upper quarter of the array. The array depth is set by `ADDR_W`: the full 8192-byte part uses `ADDR_W = 13`, and the default of 11 keeps elaboration small. The word address is always sent as two bytes, high byte first, and only its low `ADDR_W` bits are used. The bus pins are plain control pins with no stream handshake. The master owns SCL, START and STOP, and the block applies no back-pressure: it never stretches the clock.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: SDA is open drain. The block only asserts `sda_oe` to pull the line low. `sda_oe` is 0 out of reset and after every STOP, and it changes only while the synchronised SCL is low.
- R2: The block acknowledges a device address byte only when its upper seven bits equal binary 1010 followed by `strap_i[2:0]` (bit 0 is R/W, 1 = read). Any other address is not acknowledged, and SDA stays released for the rest of that transaction.
- R3: A write transaction sends the device address with R/W = 0, then the word address high byte and low byte, then data bytes, each acknowledged. The data reach the array only after STOP, and a later random read returns them.
- R4: Within one write, the low 5 address bits advance and wrap inside the current 32-byte page. A 33rd or later byte overwrites the byte loaded 32 positions earlier.
- R5: A STOP that ends a write carrying at least one data byte starts a programming window of `WR_CYCLES` system clocks. During the window the device address is not acknowledged and SDA is never pulled low. After the window the device address is acknowledged again.
- R6: While `wp_i` is 1, bytes addressed to the top quarter of the array (top two address bits both 1) are not changed. Bytes below that boundary are still written. With `wp_i` at 0, the whole array is writable.
- R7: A sequential read returns consecutive bytes while the master acknowledges. The counter wraps from the last address to 0.
- R8: A read with no preceding word address (current-address read) starts at the byte after the last one read.
- R9: A START at any point, including in the middle of a byte, resets the bit counter, and the next address byte is received correctly.
- R10: A write that carries only a word address and then a STOP starts no programming window, so the device address is acknowledged at once afterwards.
- R11: A master NACK after a read byte ends the read. The block releases SDA and waits for START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pin |
| sda_i | input | 1 | Bus data as seen at the pin (wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Device address strap bits, low when unconnected |
| wp_i | input | 1 | 1 protects the top quarter of the array |
| | | | |

## Verification
The assertions check, on every cycle, that the block changes its SDA drive only while SCL is low, that it drives nothing during a programming window, and that each window lasts exactly `WR_CYCLES` clocks. They also check that array writes happen only inside a window and never reach the protected quarter while protection is on, and that START clears the bit counter. Whether the right bytes land at the right addresses can only be shown by the bench's scenarios, by reading data back over the bus. That covers page wrap and overwrite order, counter wrap at the top of the array, current-address continuation, address matching against the straps, and recovery after an aborted byte.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ACKDEV, S_AHI, S_ACKAHI, S_ALO, S_ACKALO,
    S_WDAT, S_ACKWD, S_RDAT, S_MACK
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_m[1];
      sda_q <= sda_m[1];
    end
  end

  assign scl_hi    = scl_m[1];
  assign sda_lvl   = sda_m[1];
  assign scl_rise  = scl_m[1] & ~scl_q;
  assign scl_fall  = ~scl_m[1] & scl_q;
  assign start_det = scl_m[1] & scl_q & sda_q & ~sda_m[1];
  assign stop_det  = scl_m[1] & scl_q & ~sda_q & sda_m[1];
endmodule

// File: rtl/eeprom_page_buffer.sv
module eeprom_page_buffer #(
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_data,
  output logic             rd_valid
);
  logic [PAGE_BYTES*8-1:0] data_flat;
  logic [PAGE_BYTES-1:0]   vld_flat;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic [7:0] q;
    logic       v;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
        v <= 1'b0;
      end else if (clr) begin
        v <= 1'b0;
      end else if (we && wr_off == OFF_W'(i)) begin
        q <= wr_data;
        v <= 1'b1;
      end
    end
    assign data_flat[i*8 +: 8] = q;
    assign vld_flat[i]         = v;
  end

  always_comb begin
    rd_data  = '0;
    rd_valid = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (rd_off == OFF_W'(i)) begin
        rd_data  = data_flat[i*8 +: 8];
        rd_valid = vld_flat[i];
      end
    end
  end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 2000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int CNT_W  = $clog2(WR_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              wp_i,
  input  logic              pb_valid,
  input  logic [7:0]        pb_data,
  output logic [OFF_W-1:0]  pb_rd_off,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic [CNT_W-1:0]  busy_cnt,
  output logic              done
);
  logic [PAGE_W-1:0] base;
  logic              in_commit, prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      busy_cnt <= '0;
      base     <= '0;
    end else if (!busy) begin
      if (go) begin
        busy     <= 1'b1;
        busy_cnt <= '0;
        base     <= page_in;
      end
    end else if (done) begin
      busy     <= 1'b0;
      busy_cnt <= '0;
    end else begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  assign done      = busy && (busy_cnt == CNT_W'(WR_CYCLES - 1));
  assign in_commit = busy && (busy_cnt < CNT_W'(PAGE_BYTES));
  assign pb_rd_off = busy_cnt[OFF_W-1:0];
  assign mem_waddr = {base, pb_rd_off};
  assign mem_wdata = pb_data;
  assign prot      = wp_i && (mem_waddr[ADDR_W-1 -: 2] == 2'b11);
  assign mem_we    = in_commit && pb_valid && !prot;
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(WR_CYCLES);

  logic scl_hi, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  bus_st_e           st;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, txbyte, addr_hi;
  logic [ADDR_W-1:0] addr;
  logic              rw, sda_oe_q, wr_pending;

  logic              busy, prog_done, mem_we, pb_valid;
  logic [CNT_W-1:0]  busy_cnt;
  logic [OFF_W-1:0]  pb_rd_off;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata, mem_rdata, pb_rdata;

  logic byte_end, no_cond, dev_hit, pb_we, addr_load, prog_go;

  i2c_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  assign no_cond   = !start_det && !stop_det;
  assign byte_end  = scl_fall && (bitcnt == 4'd8);
  assign dev_hit   = (shreg[7:1] == {DEV_PREFIX, strap_i}) && !busy;
  assign pb_we     = (st == S_WDAT) && byte_end && no_cond;
  assign addr_load = (st == S_ALO) && byte_end && no_cond;
  assign prog_go   = stop_det && wr_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      txbyte     <= '0;
      addr_hi    <= '0;
      addr       <= '0;
      rw         <= 1'b0;
      sda_oe_q   <= 1'b0;
      wr_pending <= 1'b0;
    end else if (start_det) begin
      st       <= S_DEV;
      bitcnt   <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      st         <= S_IDLE;
      bitcnt     <= '0;
      sda_oe_q   <= 1'b0;
      wr_pending <= 1'b0;
    end else begin
      unique case (st)
        S_DEV, S_AHI, S_ALO, S_WDAT: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_end) begin
            bitcnt <= '0;
            if (st == S_DEV) begin
              if (dev_hit) begin
                rw       <= shreg[0];
                sda_oe_q <= 1'b1;
                st       <= S_ACKDEV;
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_AHI) begin
              addr_hi  <= shreg;
              sda_oe_q <= 1'b1;
              st       <= S_ACKAHI;
            end else if (st == S_ALO) begin
              addr       <= ADDR_W'({addr_hi, shreg});
              wr_pending <= 1'b0;
              sda_oe_q   <= 1'b1;
              st         <= S_ACKALO;
            end else begin
              addr       <= {addr[ADDR_W-1:OFF_W], addr[OFF_W-1:0] + 1'b1};
              wr_pending <= 1'b1;
              sda_oe_q   <= 1'b1;
              st         <= S_ACKWD;
            end
          end
        end
        S_ACKDEV: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              txbyte   <= mem_rdata;
              addr     <= addr + 1'b1;
              sda_oe_q <= ~mem_rdata[7];
              st       <= S_RDAT;
            end else begin
              sda_oe_q <= 1'b0;
              st       <= S_AHI;
            end
          end
        end
        S_ACKAHI: if (scl_fall) begin sda_oe_q <= 1'b0; st <= S_ALO;  end
        S_ACKALO: if (scl_fall) begin sda_oe_q <= 1'b0; st <= S_WDAT; end
        S_ACKWD:  if (scl_fall) begin sda_oe_q <= 1'b0; st <= S_WDAT; end
        S_RDAT: begin
          if (scl_rise) bitcnt <= bitcnt + 1'b1;
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe_q <= 1'b0;
              st       <= S_MACK;
            end else begin
              sda_oe_q <= ~txbyte[6];
              txbyte   <= {txbyte[6:0], 1'b0};
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            if (!sda_lvl) bitcnt <= 4'd9;
            else          st     <= S_IDLE;
          end
          if (scl_fall && bitcnt == 4'd9) begin
            bitcnt   <= '0;
            txbyte   <= mem_rdata;
            addr     <= addr + 1'b1;
            sda_oe_q <= ~mem_rdata[7];
            st       <= S_RDAT;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = sda_oe_q;

  eeprom_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(addr_load || prog_done),
    .we(pb_we), .wr_off(addr[OFF_W-1:0]), .wr_data(shreg),
    .rd_off(pb_rd_off), .rd_data(pb_rdata), .rd_valid(pb_valid)
  );

  eeprom_prog_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
  ) u_prog (
    .clk(clk), .rst_n(rst_n), .go(prog_go),
    .page_in(addr[ADDR_W-1 -: PAGE_W]), .wp_i(wp_i),
    .pb_valid(pb_valid), .pb_data(pb_rdata), .pb_rd_off(pb_rd_off),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .busy(busy), .busy_cnt(busy_cnt), .done(prog_done)
  );

  eeprom_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/eeprom_chk.sv
module eeprom_chk #(
  parameter int ADDR_W    = 11,
  parameter int WR_CYCLES = 2000,
  localparam int CNT_W = $clog2(WR_CYCLES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_hi,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              busy,
  input logic [CNT_W-1:0]  busy_cnt,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic              wp_i,
  input logic [3:0]        bitcnt
);
  // R1
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_hi) || $past(start_det) || $past(stop_det)));

  // R5
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(busy_cnt) == CNT_W'(WR_CYCLES - 1)));

  // R3
  commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wp_i) |-> (mem_waddr[ADDR_W-1 -: 2] != 2'b11));

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bitcnt == 4'd0));
endmodule

bind i2c_eeprom_slave eeprom_chk #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_hi(scl_hi), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .busy(busy), .busy_cnt(busy_cnt),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .wp_i(wp_i), .bitcnt(bitcnt)
);

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int ADDR_W = 11;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WR_CYC = 2000;
  localparam int Q      = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  bus_sda = m_sda & ~sda_oe;

  int checks = 0, errors = 0;
  logic [7:0] refm [0:DEPTH-1];

  always #5 clk = ~clk;

  i2c_eeprom_slave #(.ADDR_W(ADDR_W), .PAGE_BYTES(32), .WR_CYCLES(WR_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
    .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    m_sda = 1; wq(Q); m_scl = 1; wq(Q); m_sda = 0; wq(Q); m_scl = 0; wq(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 0; wq(Q); m_scl = 1; wq(Q); m_sda = 1; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); m_scl = 1; wq(2*Q); m_scl = 0; wq(Q);
    end
    m_sda = 1; wq(Q); m_scl = 1; wq(Q); ack = ~bus_sda; wq(Q); m_scl = 0; wq(Q);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 0; i < 8; i++) begin
      wq(Q); m_scl = 1; wq(Q); b = {b[6:0], bus_sda}; wq(Q); m_scl = 0;
    end
    wq(Q); m_sda = ~mack; wq(Q); m_scl = 1; wq(2*Q); m_scl = 0; wq(Q); m_sda = 1;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic send_addr(input int a, input string req);
    logic ack;
    wbyte(DEV_W, ack);       chk(ack, req, ack, 1);
    wbyte(8'(a >> 8), ack);  chk(ack, req, ack, 1);
    wbyte(8'(a), ack);       chk(ack, req, ack, 1);
  endtask

  task automatic wr_seq(input int a, input int n, input int seed, input string req);
    logic ack;
    int base, off;
    base = a & ~31;
    i2c_start;
    send_addr(a, req);
    for (int i = 0; i < n; i++) begin
      wbyte(pat(seed, i), ack);
      chk(ack, req, ack, 1);
      off = ((a & 31) + i) & 31;
      if (!(wp && ((base + off) >= (DEPTH * 3 / 4)))) refm[base + off] = pat(seed, i);
    end
    i2c_stop;
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    wq(WR_CYC + 100);
  endtask

  task automatic rd_seq(input int a, input int n, input string req);
    logic ack;
    logic [7:0] b;
    i2c_start;
    send_addr(a, req);
    i2c_start;
    wbyte(DEV_R, ack); chk(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i < n - 1, b);
      chk(b == refm[(a + i) % DEPTH], req, b, refm[(a + i) % DEPTH]);
    end
    wq(2);
    chk(sda_oe == 1'b0, "R11", sda_oe, 0);
    i2c_stop;
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    wq(5);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
  endtask

  task automatic t_addr_match;
    logic ack;
    i2c_start;
    wbyte({4'b1010, 3'b100, 1'b0}, ack); chk(!ack, "R2", ack, 0);
    wbyte(8'h55, ack);                   chk(!ack, "R2", ack, 0);
    i2c_stop;
    i2c_start;
    wbyte({4'b1011, STRAP, 1'b0}, ack);  chk(!ack, "R2", ack, 0);
    i2c_stop;
    i2c_start;
    wbyte(DEV_W, ack);                   chk(ack, "R2", ack, 1);
    i2c_stop;
  endtask

  task automatic t_page_write;
    wr_seq(11'h123, 8, 3, "R3");
    rd_seq(11'h123, 8, "R3");
  endtask

  task automatic t_addr_only;
    logic ack;
    i2c_start;
    send_addr(11'h040, "R10");
    i2c_stop;
    i2c_start;
    wbyte(DEV_W, ack); chk(ack, "R10", ack, 1);
    i2c_stop;
  endtask

  task automatic t_abort;
    logic ack;
    logic [7:0] b;
    i2c_start;
    for (int i = 0; i < 5; i++) begin
      m_sda = 1; wq(Q); m_scl = 1; wq(2*Q); m_scl = 0; wq(Q);
    end
    i2c_start;
    send_addr(11'h125, "R9");
    i2c_start;
    wbyte(DEV_R, ack); chk(ack, "R9", ack, 1);
    rbyte(1'b0, b);    chk(b == refm[11'h125], "R9", b, refm[11'h125]);
    i2c_stop;
  endtask

  task automatic t_wrap;
    wr_seq(11'h05E, 34, 7, "R4");
    rd_seq(11'h040, 32, "R4");
  endtask

  task automatic t_busy;
    logic ack;
    i2c_start;
    send_addr(11'h200, "R5");
    wbyte(8'hA5, ack); chk(ack, "R5", ack, 1);
    refm[11'h200] = 8'hA5;
    i2c_stop;
    i2c_start;
    wbyte(DEV_W, ack); chk(!ack, "R5", ack, 0);
    i2c_stop;
    wq(WR_CYC);
    i2c_start;
    wbyte(DEV_W, ack); chk(ack, "R5", ack, 1);
    i2c_stop;
    rd_seq(11'h200, 1, "R5");
  endtask

  task automatic t_wp;
    wp = 0;
    wr_seq(11'h7F0, 4, 11, "R6");
    wp = 1;
    wr_seq(11'h7F0, 4, 12, "R6");
    wr_seq(11'h5FC, 4, 13, "R6");
    wp = 0;
    rd_seq(11'h7F0, 4, "R6");
    rd_seq(11'h5FC, 4, "R6");
  endtask

  task automatic t_seq_cur;
    logic ack;
    logic [7:0] b;
    wr_seq(11'h7FE, 2, 21, "R7");
    wr_seq(11'h000, 4, 22, "R7");
    rd_seq(11'h7FE, 5, "R7");
    i2c_start;
    wbyte(DEV_R, ack); chk(ack, "R8", ack, 1);
    rbyte(1'b0, b);    chk(b == refm[11'h003], "R8", b, refm[11'h003]);
    i2c_stop;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wq(4);
    t_reset;
    rst_n = 1;
    wq(10);
    t_reset;
    t_addr_match;
    t_page_write;
    t_addr_only;
    t_abort;
    t_wrap;
    t_busy;
    t_wp;
    t_seq_cur;
    finish_run;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run;
  end
endmodule